// File: doc/BRIEF.md
# Pseudo-static RAM refresh configuration controller

This block keeps the eight-bit refresh configuration register of a pseudo-static RAM and turns it into the controls that govern self refresh. The register can be loaded through a dedicated configuration-enable write path, or through a software write path that may never touch the power-down control. From the stored value the block derives four things: whether refresh runs at all, how long the refresh interval is, whether page mode is on for asynchronous reads, and whether a given word address lies inside the part of the array that is kept refreshed.

Refresh stops completely while the power-down control bit holds 0. In that state every location counts as lost. When the bit returns to 1, the block holds its ready output low for a parameterized number of clock cycles. This wait stands for the initialization time of roughly 150 microseconds. The refreshed section can be the whole array, nothing, or a half, a quarter or an eighth taken from either the bottom or the top of the address space. An access strobe returns, one cycle later, a flag that marks the data at that address as unreliable.

Top module: `psram_rcfg_ctrl`

## Requirements
- R1: After reset the register reads 0x10, ready and refresh_en are 1, page_en is 0 and refi_cycles equals REFI_BASE.
- R2: A write on the configuration-enable path (cfg_we) stores bits 7:4 and 2:0 of cfg_wdata. Bit 3 is reserved and always reads 0.
- R3: A write on the software path (sw_we) with cfg_we low updates bits 7:5 and 2:0 and leaves bit 4 unchanged. Bit 3 reads 0. When both write strobes are high, the configuration-enable path wins.
- R4: While bit 4 is 0 (power-down), refresh_en, ready and retained are all 0 for every address.
- R5: A configuration-enable write that takes bit 4 from 0 to 1 drives ready low. Ready rises exactly INIT_CYCLES clock edges after the write edge.
- R6: A configuration-enable write that keeps bit 4 at 1 during the wait still stores its other fields, and it neither restarts nor shortens the wait.
- R7: With bit 4 at 1, code 000 in bits 2:0 keeps the whole array. Codes 001, 010 and 011 keep the lowest half, quarter and eighth: an address is kept when its top one, two or three bits are all 0.
- R8: With bit 4 at 1, code 100 keeps no address. Codes 101, 110 and 111 keep the highest half, quarter and eighth: an address is kept when its top one, two or three bits are all 1.
- R9: refi_cycles equals REFI_BASE shifted left by bits 6:5. Code 00 stands for the warmest setting, which gives the shortest interval. Codes 01, 10 and 11 stand for progressively cooler settings with longer intervals.
- R10: page_en equals bit 7 of the register.
- R11: An acc_valid pulse produces rsp_valid on the next cycle. With it comes data_invalid, set when the address was not kept (outside the section, or during power-down) at the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration-enable path write strobe |
| cfg_wdata | input | 8 | Configuration-enable path write data |
| sw_we | input | 1 | Software path write strobe |
| sw_wdata | input | 8 | Software path write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Word address of the access |
| cfg_q | output | 8 | Current register value |
| refresh_en | output | 1 | Refresh running (not in power-down) |
| ready | output | 1 | Accesses accepted (not in power-down and not waiting) |
| refi_cycles | output | REFI_W | Selected refresh interval in clock cycles |
| page_en | output | 1 | Page mode enable for asynchronous reads |
| retained | output | 1 | Address acc_addr lies in the refreshed section |
| rsp_valid | output | 1 | Access result valid |
| data_invalid | output | 1 | Accessed data is not reliable |

## Verification
The section decode is exercised with all eight section codes against one address list. The list holds both neighbours of every half, quarter and eighth boundary at the bottom and at the top. This separates the bottom variants from the top variants, and a one-bit-too-wide mask from a correct one. The write paths are tried with the power-down bit set differently from the current value, so that a software write that leaks bit 4 shows up. The wait is tried twice: once alone, to count its exact length, and once with a configuration write landing in the middle of it, which shows whether that write restarts the count or cuts it short.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam logic [7:0] RCR_RESET   = 8'h10;
  localparam logic [7:0] CFG_WR_MASK = 8'hF7;
  localparam logic [7:0] SW_WR_MASK  = 8'hE7;
  localparam logic [7:0] DPD_MASK    = 8'h10;

  typedef struct packed {
    logic       page;
    logic [1:0] tcr;
    logic       dpd_n;
    logic       rsvd;
    logic [2:0] par;
  } rcr_t;
endpackage

// File: rtl/rcfg_regs.sv
module rcfg_regs
  import rcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       sw_we,
  input  logic [7:0] sw_wdata,
  output rcr_t       rcr_q,
  output logic       wake
);
  rcr_t rcr_d;
  logic load_en;

  always_comb begin
    load_en = cfg_we | sw_we;
    rcr_d   = rcr_q;
    if (cfg_we) begin
      rcr_d = rcr_t'(cfg_wdata & CFG_WR_MASK);
    end else if (sw_we) begin
      // software path never moves the power-down control
      rcr_d = rcr_t'((sw_wdata & SW_WR_MASK) | (rcr_q & DPD_MASK));
    end
    wake = cfg_we & ~rcr_q.dpd_n & cfg_wdata[4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcr_q <= rcr_t'(RCR_RESET);
    end else if (load_en) begin
      rcr_q <= rcr_d;
    end
  end
endmodule

// File: rtl/rcfg_init_timer.sv
module rcfg_init_timer #(
  parameter int INIT_CYCLES = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = start | busy;
    if (start) cnt_d = CW'(INIT_CYCLES);
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rcfg_par_decode.sv
module rcfg_par_decode #(
  parameter int ADDR_W = 22
) (
  input  logic [2:0]        par,
  input  logic              dpd_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              keep
);
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] sel;
  logic              low_ok, high_ok;

  always_comb begin
    mask = '0;
    for (int i = 0; i < 3; i++) begin
      if (i < int'(par[1:0])) mask[ADDR_W-1-i] = 1'b1;
    end
    sel     = addr & mask;
    low_ok  = (sel == '0);
    high_ok = (sel == mask);
    if (!dpd_n)                keep = 1'b0;
    else if (par == 3'b100)    keep = 1'b0;
    else if (par[1:0] == 2'd0) keep = 1'b1;
    else if (par[2])           keep = high_ok;
    else                       keep = low_ok;
  end
endmodule

// File: rtl/rcfg_access.sv
module rcfg_access (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic keep,
  output logic rsp_valid,
  output logic data_invalid
);
  logic inv_d;

  always_comb inv_d = ~keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      data_invalid <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      if (acc_valid) data_invalid <= inv_d;
    end
  end
endmodule

// File: rtl/psram_rcfg_ctrl.sv
module psram_rcfg_ctrl
  import rcfg_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int INIT_CYCLES = 15000,
  parameter int REFI_BASE   = 64,
  localparam int REFI_W     = $clog2(REFI_BASE) + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              sw_we,
  input  logic [7:0]        sw_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [7:0]        cfg_q,
  output logic              refresh_en,
  output logic              ready,
  output logic [REFI_W-1:0] refi_cycles,
  output logic              page_en,
  output logic              retained,
  output logic              rsp_valid,
  output logic              data_invalid
);
  rcr_t rcr;
  logic wake;
  logic busy;

  rcfg_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sw_we(sw_we), .sw_wdata(sw_wdata),
    .rcr_q(rcr), .wake(wake)
  );

  rcfg_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wake), .busy(busy)
  );

  rcfg_par_decode #(.ADDR_W(ADDR_W)) u_dec (
    .par(rcr.par), .dpd_n(rcr.dpd_n), .addr(acc_addr), .keep(retained)
  );

  rcfg_access u_acc (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .keep(retained),
    .rsp_valid(rsp_valid), .data_invalid(data_invalid)
  );

  always_comb begin
    cfg_q       = rcr;
    refresh_en  = rcr.dpd_n;
    ready       = rcr.dpd_n & ~busy;
    page_en     = rcr.page;
    refi_cycles = REFI_W'(REFI_BASE) << rcr.tcr;
  end
endmodule

// File: rtl/rcfg_checker.sv
module rcfg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       sw_we,
  input logic [7:0] cfg_q,
  input logic       refresh_en,
  input logic       ready,
  input logic       retained,
  input logic       acc_valid,
  input logic       rsp_valid
);
  assert_sw_keeps_dpd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !cfg_we) |=> $stable(cfg_q[4]));

  assert_pd_blocks_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en |-> (!ready && !retained));

  assert_wake_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_en) |-> !ready);

  assert_none_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[4] && cfg_q[2:0] == 3'b100) |-> !retained);

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
endmodule

bind psram_rcfg_ctrl rcfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .sw_we(sw_we), .cfg_q(cfg_q),
  .refresh_en(refresh_en), .ready(ready), .retained(retained),
  .acc_valid(acc_valid), .rsp_valid(rsp_valid)
);

// File: tb/sim_psram_rcfg_ctrl.sv
module sim_psram_rcfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int INIT = 40;
  localparam int BASE = 64;
  localparam int RW   = $clog2(BASE) + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, sw_we, acc_valid;
  logic [7:0]    cfg_wdata, sw_wdata;
  logic [AW-1:0] acc_addr;
  logic [7:0]    cfg_q;
  logic          refresh_en, ready, page_en, retained, rsp_valid, data_invalid;
  logic [RW-1:0] refi_cycles;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit    exp_q[$];
  string tag_q[$];

  psram_rcfg_ctrl #(.ADDR_W(AW), .INIT_CYCLES(INIT), .REFI_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .cfg_q(cfg_q), .refresh_en(refresh_en), .ready(ready), .refi_cycles(refi_cycles),
    .page_en(page_en), .retained(retained), .rsp_valid(rsp_valid),
    .data_invalid(data_invalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_keep(logic [7:0] c, int a);
    int n = 1 << AW;
    if (!c[4]) return 1'b0;
    case (c[2:0])
      3'd0: return 1'b1;
      3'd1: return a < n / 2;
      3'd2: return a < n / 4;
      3'd3: return a < n / 8;
      3'd4: return 1'b0;
      3'd5: return a >= n / 2;
      3'd6: return a >= n - n / 4;
      default: return a >= n - n / 8;
    endcase
  endfunction

  task automatic cfg_write(logic [7:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic sw_write(logic [7:0] d);
    @(posedge clk); #1;
    sw_we = 1'b1; sw_wdata = d;
    @(posedge clk); #1;
    sw_we = 1'b0;
  endtask

  // driver: pushes expected data_invalid, checks the combinational flag
  task automatic access(int a, string tag);
    bit k;
    @(posedge clk); #1;
    k = ref_keep(cfg_q, a);
    acc_valid = 1'b1; acc_addr = AW'(a);
    exp_q.push_back(!k);
    tag_q.push_back(tag);
    #1 check({tag, " retained"}, retained, k);
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  // monitor: pops and compares each response (R11)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected rsp", 1, 0);
      else begin
        string t = tag_q.pop_front();
        check({t, " R11 data_invalid"}, data_invalid, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int addrs[12] = '{0, 'h1F, 'h20, 'h3F, 'h40, 'h7F, 'h80, 'hBF, 'hC0, 'hDF, 'hE0, 'hFF};
    int start_cyc;
    rst_n = 1'b0; cfg_we = 1'b0; sw_we = 1'b0; acc_valid = 1'b0;
    cfg_wdata = '0; sw_wdata = '0; acc_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 cfg_q", cfg_q, 8'h10);
    check("R1 ready", ready, 1);
    check("R1 refresh_en", refresh_en, 1);
    check("R1 page_en", page_en, 0);
    check("R1 refi", refi_cycles, BASE);
    access(0, "R7 full");
    access('hFF, "R7 full");

    // R2: reserved bit dropped; R10 and R9 follow fields
    cfg_write(8'hF9);
    check("R2 cfg_q", cfg_q, 8'hF1);
    check("R10 page_en", page_en, 1);
    check("R9 refi tcr3", refi_cycles, BASE << 3);
    check("R6 no wait without wake", ready, 1);

    // R7 / R8: every section code over both sides of each boundary
    for (int c = 0; c < 8; c++) begin
      cfg_write(8'h10 | 8'(c));
      foreach (addrs[i]) access(addrs[i], (c < 4) ? "R7" : "R8");
    end

    for (int t = 0; t < 4; t++) begin
      cfg_write(8'h10 | 8'(t << 5));
      check("R9 refi", refi_cycles, BASE << t);
      check("R10 page off", page_en, 0);
    end

    // R3: software write with bit 4 low and bit 3 high
    sw_write(8'hAA);
    check("R3 sw keeps bit4", cfg_q, 8'hB2);
    check("R3 refresh_en", refresh_en, 1);
    check("R3 ready", ready, 1);
    @(posedge clk); #1;
    sw_we = 1'b1; sw_wdata = 8'h00; cfg_we = 1'b1; cfg_wdata = 8'h15;
    @(posedge clk); #1;
    sw_we = 1'b0; cfg_we = 1'b0;
    check("R3 cfg wins", cfg_q, 8'h15);

    // R4: power-down
    cfg_write(8'h00);
    check("R4 refresh_en", refresh_en, 0);
    check("R4 ready", ready, 0);
    access(0, "R4");
    access('hFF, "R4");
    sw_write(8'h10);
    check("R3 sw cannot exit", cfg_q, 8'h00);
    check("R4 still down", refresh_en, 0);

    // R5: exact wait length
    cfg_write(8'h10);
    start_cyc = cyc;
    check("R5 ready low at wake", ready, 0);
    check("R5 refresh_en", refresh_en, 1);
    while (!ready && cyc < start_cyc + 2 * INIT) begin @(posedge clk); #1; end
    check("R5 rise cycle", cyc - start_cyc, INIT);

    // R6: write in the middle of the wait
    cfg_write(8'h00);
    cfg_write(8'h10);
    start_cyc = cyc;
    repeat (10) begin @(posedge clk); #1; end
    cfg_write(8'h93);
    check("R6 stored mid-wait", cfg_q, 8'h93);
    check("R6 still waiting", ready, 0);
    while (!ready && cyc < start_cyc + 2 * INIT) begin @(posedge clk); #1; end
    check("R6 rise cycle", cyc - start_cyc, INIT);
    access('h3F, "R6 after wait");
    access('h40, "R6 after wait");

    repeat (3) @(posedge clk);
    #1 check("R11 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule